// File: doc/BRIEF.md
# Endianness Control Bit Register

This block keeps the three byte-order control bits of a status CSR: one for machine mode, one for supervisor mode and one for user mode. Software reaches them through three CSR views. The machine status view is at address 0x300. The supervisor status view is at 0x100. On 32-bit builds, a machine upper-half view sits at 0x310. All three views share one set of storage flops.

Each write is legalized before it is stored. The machine bit always takes the written value. The supervisor bit and the user bit take it only when their privilege mode is built in; otherwise they stay at zero. The three bits go straight from their flops to the load/store path, so a write is seen there from the cycle after its clock edge.

Reads are registered. The data comes back one cycle after the read strobe, together with a hit flag that marks a valid address.

Top module: `endian_status_reg`

## Requirements
- R1: After a synchronous reset, all three endian bits are 0 and reads through every view return 0.
- R2: In the machine status view (0x300), the user bit is at bit 6. On 64-bit builds, the supervisor bit is at bit 36 and the machine bit is at bit 37.
- R3: On 32-bit builds, the upper-half view (0x310) holds the supervisor bit at bit 4 and the machine bit at bit 5. On 64-bit builds, 0x310 is not a valid address: reads give hit 0 and writes change nothing.
- R4: The machine endian bit always takes the value written to its position.
- R5: Without supervisor mode, the supervisor bit stays 0 whatever is written.
- R6: Without user mode, the user bit stays 0 whatever is written.
- R7: The supervisor view (0x100) shows the user bit at bit 6, using the same storage as the machine view. It never shows the supervisor or machine bits, and writes through it leave those two bits unchanged.
- R8: A write updates the bits at its clock edge. A read in the same cycle as a write returns the value from before the write.
- R9: A read of any other address returns hit 0 and data 0 one cycle later. A write to any other address changes no bit.
- R10: Every bit position other than the endian bits reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address for the read and/or write of this cycle |
| csr_wr_en | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rd_en | input | 1 | Read strobe |
| csr_rd_valid | output | 1 | Read result valid, one cycle after csr_rd_en |
| csr_rd_hit | output | 1 | Read address was a valid view |
| csr_rdata | output | XLEN | Read data |
| mem_be_m | output | 1 | Machine-mode big-endian bit to the memory path |
| mem_be_s | output | 1 | Supervisor-mode big-endian bit to the memory path |
| mem_be_u | output | 1 | User-mode big-endian bit to the memory path |

## Verification
The assertions assume that the strobes and the address are known (never X) whenever reset is low, and that XLEN is 32 or 64. They also assume that a write and a read in the same cycle target the same address, because a single address port is shared. The stimulus changes inputs only on the falling clock edge and always drives defined values. It exercises all three views on a 32-bit instance with every mode present, and on two 64-bit instances: one with the supervisor and user modes removed, one with every mode present.

// File: rtl/endian_pkg.sv
package endian_pkg;
  localparam int unsigned CSR_AW = 12;

  localparam logic [CSR_AW-1:0] ADDR_MACH_STAT    = 12'h300;
  localparam logic [CSR_AW-1:0] ADDR_MACH_STAT_HI = 12'h310;
  localparam logic [CSR_AW-1:0] ADDR_SUP_STAT     = 12'h100;

  // bit positions inside each view
  localparam int unsigned POS_USR      = 6;
  localparam int unsigned POS_SUP_FULL = 36;
  localparam int unsigned POS_MACH_FULL = 37;
  localparam int unsigned POS_SUP_HI   = 4;
  localparam int unsigned POS_MACH_HI  = 5;

  typedef enum logic [1:0] {
    VIEW_NONE,
    VIEW_MACH,
    VIEW_MACH_HI,
    VIEW_SUP
  } csr_view_e;

  typedef struct packed {
    logic mach;
    logic sup;
    logic usr;
  } endian_set_t;
endpackage

// File: rtl/endian_view_decode.sv
module endian_view_decode import endian_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input  logic [CSR_AW-1:0] addr,
  output csr_view_e         view
);
  localparam bit HAS_HI_VIEW = (XLEN == 32);

  always_comb begin
    case (addr)
      ADDR_MACH_STAT:    view = VIEW_MACH;
      ADDR_MACH_STAT_HI: view = HAS_HI_VIEW ? VIEW_MACH_HI : VIEW_NONE;
      ADDR_SUP_STAT:     view = VIEW_SUP;
      default:           view = VIEW_NONE;
    endcase
  end
endmodule

// File: rtl/endian_write_sel.sv
module endian_write_sel import endian_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input  csr_view_e       view,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output endian_set_t     bit_we,
  output endian_set_t     bit_val
);
  localparam bit WIDE_MAP = (XLEN == 64);

  logic [63:0] wide;
  logic        unused_wide;

  assign wide        = 64'(wdata);
  assign unused_wide = ^wide;

  always_comb begin
    bit_we  = '0;
    bit_val = '0;
    if (wr_en) begin
      case (view)
        VIEW_MACH: begin
          bit_we.usr  = 1'b1;
          bit_val.usr = wide[POS_USR];
          if (WIDE_MAP) begin
            bit_we.sup   = 1'b1;
            bit_we.mach  = 1'b1;
            bit_val.sup  = wide[POS_SUP_FULL];
            bit_val.mach = wide[POS_MACH_FULL];
          end
        end
        VIEW_MACH_HI: begin
          bit_we.sup   = 1'b1;
          bit_we.mach  = 1'b1;
          bit_val.sup  = wide[POS_SUP_HI];
          bit_val.mach = wide[POS_MACH_HI];
        end
        VIEW_SUP: begin
          bit_we.usr  = 1'b1;
          bit_val.usr = wide[POS_USR];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/endian_bit_cell.sv
module endian_bit_cell #(
  parameter bit   PRESENT = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  generate
    if (PRESENT) begin : g_store
      logic state;
      always_ff @(posedge clk) begin
        if (rst)        state <= RST_VAL;
        else if (wr_en) state <= wr_val;
      end
      assign q = state;
    end else begin : g_tied
      logic unused_cell;
      assign unused_cell = clk ^ rst ^ wr_en ^ wr_val;
      assign q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/endian_read_pack.sv
module endian_read_pack import endian_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input  csr_view_e       view,
  input  endian_set_t     cur,
  output logic            hit,
  output logic [XLEN-1:0] data
);
  localparam bit WIDE_MAP = (XLEN == 64);

  logic [63:0] word;

  always_comb begin
    word = '0;
    hit  = 1'b1;
    case (view)
      VIEW_MACH: begin
        word[POS_USR] = cur.usr;
        if (WIDE_MAP) begin
          word[POS_SUP_FULL]  = cur.sup;
          word[POS_MACH_FULL] = cur.mach;
        end
      end
      VIEW_MACH_HI: begin
        word[POS_SUP_HI]  = cur.sup;
        word[POS_MACH_HI] = cur.mach;
      end
      VIEW_SUP: word[POS_USR] = cur.usr;
      default:  hit = 1'b0;
    endcase
    data = XLEN'(word);
  end
endmodule

// File: rtl/endian_status_reg.sv
module endian_status_reg import endian_pkg::*; #(
  parameter int unsigned XLEN      = 32,
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wr_en,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              csr_rd_en,
  output logic              csr_rd_valid,
  output logic              csr_rd_hit,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              mem_be_m,
  output logic              mem_be_s,
  output logic              mem_be_u
);
  csr_view_e   view;
  endian_set_t bit_we;
  endian_set_t bit_val;
  endian_set_t cur;
  logic            pack_hit;
  logic [XLEN-1:0] pack_data;

  endian_view_decode #(.XLEN(XLEN)) i_decode (
    .addr (csr_addr),
    .view (view)
  );

  endian_write_sel #(.XLEN(XLEN)) i_wsel (
    .view    (view),
    .wr_en   (csr_wr_en),
    .wdata   (csr_wdata),
    .bit_we  (bit_we),
    .bit_val (bit_val)
  );

  endian_bit_cell #(.PRESENT(1'b1), .RST_VAL(1'b0)) i_cell_m (
    .clk (clk), .rst (rst), .wr_en (bit_we.mach), .wr_val (bit_val.mach), .q (cur.mach)
  );

  endian_bit_cell #(.PRESENT(HAS_SMODE), .RST_VAL(1'b0)) i_cell_s (
    .clk (clk), .rst (rst), .wr_en (bit_we.sup), .wr_val (bit_val.sup), .q (cur.sup)
  );

  endian_bit_cell #(.PRESENT(HAS_UMODE), .RST_VAL(1'b0)) i_cell_u (
    .clk (clk), .rst (rst), .wr_en (bit_we.usr), .wr_val (bit_val.usr), .q (cur.usr)
  );

  endian_read_pack #(.XLEN(XLEN)) i_rpack (
    .view (view),
    .cur  (cur),
    .hit  (pack_hit),
    .data (pack_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rd_valid <= 1'b0;
      csr_rd_hit   <= 1'b0;
      csr_rdata    <= '0;
    end else begin
      csr_rd_valid <= csr_rd_en;
      csr_rd_hit   <= csr_rd_en & pack_hit;
      csr_rdata    <= (csr_rd_en && pack_hit) ? pack_data : '0;
    end
  end

  assign mem_be_m = cur.mach;
  assign mem_be_s = cur.sup;
  assign mem_be_u = cur.usr;
endmodule

// File: rtl/endian_status_chk.sv
module endian_status_chk #(
  parameter int unsigned XLEN      = 32,
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [11:0]     csr_addr,
  input logic            csr_wr_en,
  input logic            csr_rd_en,
  input logic            csr_rd_hit,
  input logic [XLEN-1:0] csr_rdata,
  input logic            mem_be_m,
  input logic            mem_be_s,
  input logic            mem_be_u
);
  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(rst)) |-> (!mem_be_m && !mem_be_s && !mem_be_u)); // R1

  AST_SUP_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (HAS_SMODE == 1'b0) |-> !mem_be_s); // R5

  AST_USR_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (HAS_UMODE == 1'b0) |-> !mem_be_u); // R6

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(rst) && !$past(csr_wr_en))
      |-> ($stable(mem_be_m) && $stable(mem_be_s) && $stable(mem_be_u))); // R8

  AST_SVIEW_KEEPS_HIGHER: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(rst) && $past(csr_wr_en) && $past(csr_addr) == 12'h100)
      |-> ($stable(mem_be_m) && $stable(mem_be_s))); // R7

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(rst) && $past(csr_wr_en) && $past(csr_addr) != 12'h300 &&
     $past(csr_addr) != 12'h310 && $past(csr_addr) != 12'h100)
      |-> ($stable(mem_be_m) && $stable(mem_be_s) && $stable(mem_be_u))); // R9

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !csr_rd_hit |-> (csr_rdata == '0)); // R9

  AST_NO_HI_VIEW_WIDE: assert property (@(posedge clk) disable iff (rst)
    (XLEN != 32 && past_valid && $past(csr_rd_en) && $past(csr_addr) == 12'h310)
      |-> !csr_rd_hit); // R3
endmodule

bind endian_status_reg endian_status_chk #(
  .XLEN(XLEN), .HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .csr_addr   (csr_addr),
  .csr_wr_en  (csr_wr_en),
  .csr_rd_en  (csr_rd_en),
  .csr_rd_hit (csr_rd_hit),
  .csr_rdata  (csr_rdata),
  .mem_be_m   (mem_be_m),
  .mem_be_s   (mem_be_s),
  .mem_be_u   (mem_be_u)
);

// File: tb/test_endian_status_reg.sv
module test_endian_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // 32-bit instance, all modes
  logic [11:0] a_addr = '0;
  logic        a_we = 1'b0, a_re = 1'b0;
  logic [31:0] a_wdata = '0;
  logic        a_valid, a_hit, a_m, a_s, a_u;
  logic [31:0] a_rdata;

  // shared drive for two 64-bit instances
  logic [11:0] w_addr = '0;
  logic        w_we = 1'b0, w_re = 1'b0;
  logic [63:0] w_wdata = '0;
  logic        b_valid, b_hit, b_m, b_s, b_u;
  logic [63:0] b_rdata;
  logic        c_valid, c_hit, c_m, c_s, c_u;
  logic [63:0] c_rdata;

  endian_status_reg #(.XLEN(32), .HAS_SMODE(1'b1), .HAS_UMODE(1'b1)) i_endian_status_reg (
    .clk(clk), .rst(rst), .csr_addr(a_addr), .csr_wr_en(a_we), .csr_wdata(a_wdata),
    .csr_rd_en(a_re), .csr_rd_valid(a_valid), .csr_rd_hit(a_hit), .csr_rdata(a_rdata),
    .mem_be_m(a_m), .mem_be_s(a_s), .mem_be_u(a_u));

  endian_status_reg #(.XLEN(64), .HAS_SMODE(1'b0), .HAS_UMODE(1'b0)) i_endian_status_reg_b (
    .clk(clk), .rst(rst), .csr_addr(w_addr), .csr_wr_en(w_we), .csr_wdata(w_wdata),
    .csr_rd_en(w_re), .csr_rd_valid(b_valid), .csr_rd_hit(b_hit), .csr_rdata(b_rdata),
    .mem_be_m(b_m), .mem_be_s(b_s), .mem_be_u(b_u));

  endian_status_reg #(.XLEN(64), .HAS_SMODE(1'b1), .HAS_UMODE(1'b1)) i_endian_status_reg_c (
    .clk(clk), .rst(rst), .csr_addr(w_addr), .csr_wr_en(w_we), .csr_wdata(w_wdata),
    .csr_rd_en(w_re), .csr_rd_valid(c_valid), .csr_rd_hit(c_hit), .csr_rdata(c_rdata),
    .mem_be_m(c_m), .mem_be_s(c_s), .mem_be_u(c_u));

  // scoreboard queues: {hit, data}
  logic [64:0] qa[$], qb[$], qc[$];
  string       ta[$], tb[$], tc[$];

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op_a(input logic we, input logic re, input logic [11:0] addr,
                      input logic [31:0] wd, input logic [64:0] exp, input string tag);
    a_we = we; a_re = re; a_addr = addr; a_wdata = wd;
    if (re) begin qa.push_back(exp); ta.push_back(tag); end
    @(negedge clk);
    a_we = 1'b0; a_re = 1'b0;
  endtask

  task automatic op_w(input logic we, input logic re, input logic [11:0] addr,
                      input logic [63:0] wd, input logic [64:0] exp_b,
                      input logic [64:0] exp_c, input string tag);
    w_we = we; w_re = re; w_addr = addr; w_wdata = wd;
    if (re) begin
      qb.push_back(exp_b); tb.push_back(tag);
      qc.push_back(exp_c); tc.push_back(tag);
    end
    @(negedge clk);
    w_we = 1'b0; w_re = 1'b0;
  endtask

  // monitors
  initial forever begin
    @(posedge clk); #2;
    if (a_valid) begin
      if (qa.size() == 0) chk("unexpected read A", 65'd1, 65'd0);
      else chk(ta.pop_front(), {a_hit, 32'h0, a_rdata}, qa.pop_front());
    end
    if (b_valid) begin
      if (qb.size() == 0) chk("unexpected read B", 65'd1, 65'd0);
      else chk(tb.pop_front(), {b_hit, b_rdata}, qb.pop_front());
    end
    if (c_valid) begin
      if (qc.size() == 0) chk("unexpected read C", 65'd1, 65'd0);
      else chk(tc.pop_front(), {c_hit, c_rdata}, qc.pop_front());
    end
  end

  function automatic logic [64:0] hd(input logic h, input logic [63:0] d);
    return {h, d};
  endfunction

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 A bits after reset", 65'({a_m, a_s, a_u}), 65'd0);
    chk("R1 B/C bits after reset", 65'({b_m, b_s, b_u, c_m, c_s, c_u}), 65'd0);
    op_a(0, 1, 12'h300, 0, hd(1, 0), "R1 read 0x300 after reset");
    op_a(0, 1, 12'h310, 0, hd(1, 0), "R1 read 0x310 after reset");
    op_a(0, 1, 12'h100, 0, hd(1, 0), "R1 read 0x100 after reset");

    // R3 R4 upper-half view on 32-bit
    op_a(1, 0, 12'h310, 32'h30, 0, "");
    chk("R3 R4 A bits after hi write", 65'({a_m, a_s, a_u}), 65'b110);
    op_a(0, 1, 12'h310, 0, hd(1, 64'h30), "R3 read hi view");
    op_a(0, 1, 12'h300, 0, hd(1, 0), "R2 low view hides m/s on 32-bit");

    // R2 R10 user bit at 6
    op_a(1, 0, 12'h300, 32'hFFFF_FFFF, 0, "");
    chk("R2 A bits after low write", 65'({a_m, a_s, a_u}), 65'b111);
    op_a(0, 1, 12'h300, 0, hd(1, 64'h40), "R10 only bit 6 reads in 0x300");

    // R7 supervisor view aliasing
    op_a(1, 0, 12'h100, 32'h0, 0, "");
    chk("R7 sview clears u keeps m/s", 65'({a_m, a_s, a_u}), 65'b110);
    op_a(1, 0, 12'h100, 32'hFFFF_FFFF, 0, "");
    chk("R7 sview sets u keeps m/s", 65'({a_m, a_s, a_u}), 65'b111);
    op_a(0, 1, 12'h100, 0, hd(1, 64'h40), "R7 R10 sview read");

    // R8 read during write returns old value
    op_a(1, 1, 12'h300, 32'h0, hd(1, 64'h40), "R8 same-cycle read old value");
    chk("R8 u cleared next cycle", 65'(a_u), 65'd0);
    op_a(0, 1, 12'h300, 0, hd(1, 0), "R8 read after write");

    // R4 machine bit cleared
    op_a(1, 0, 12'h310, 32'h10, 0, "");
    op_a(0, 1, 12'h310, 0, hd(1, 64'h10), "R4 hi view m cleared");
    chk("R4 A bits", 65'({a_m, a_s, a_u}), 65'b010);

    // R9 foreign address
    op_a(1, 0, 12'h305, 32'hFFFF_FFFF, 0, "");
    chk("R9 foreign write ignored", 65'({a_m, a_s, a_u}), 65'b010);
    op_a(0, 1, 12'h305, 0, hd(0, 0), "R9 foreign read miss");

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 A bits after second reset", 65'({a_m, a_s, a_u}), 65'd0);
    op_a(0, 1, 12'h310, 0, hd(1, 0), "R1 hi view after second reset");

    // 64-bit instances: B no S/U, C all modes
    op_w(1, 0, 12'h300, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "");
    chk("R4 R5 R6 B bits after full write", 65'({b_m, b_s, b_u}), 65'b100);
    chk("R2 C bits after full write", 65'({c_m, c_s, c_u}), 65'b111);
    op_w(0, 1, 12'h300, 0, hd(1, 64'h0000_0020_0000_0000),
         hd(1, 64'h0000_0030_0000_0040), "R2 R10 64-bit positions");
    op_w(0, 1, 12'h310, 0, hd(0, 0), hd(0, 0), "R3 no hi view on 64-bit");
    op_w(1, 0, 12'h310, 64'h0, 0, 0, "");
    chk("R3 hi write ignored on 64-bit", 65'({b_m, b_s, b_u, c_m, c_s, c_u}), 65'b100111);
    op_w(1, 0, 12'h100, 64'h0, 0, 0, "");
    chk("R7 C sview clears u only", 65'({c_m, c_s, c_u}), 65'b110);
    op_w(1, 0, 12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "");
    chk("R6 B u stays 0 via sview", 65'({b_m, b_s, b_u}), 65'b100);
    op_w(0, 1, 12'h100, 0, hd(1, 0), hd(1, 64'h40), "R7 sview read 64-bit");
    op_w(1, 0, 12'h300, 64'h0, 0, 0, "");
    chk("R4 all clear on 64-bit", 65'({b_m, b_s, b_u, c_m, c_s, c_u}), 65'd0);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 65'(qa.size() + qb.size() + qc.size()), 65'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule